// File: doc/BRIEF.md
# Edge-Timing Phase Detector with Overlap Window

This block measures how far apart in time the rising edges of two pulse-width-modulated inputs land within a shared frame, sampled on a single clock. Whichever input rises first starts its error pulse: input A drives the up pulse and input B drives the down pulse. When the later edge arrives, both pulses run together for a fixed overlap of `DELAY` clock cycles and then end in the same cycle. The difference between the two pulse widths is therefore exactly the edge separation, measured in clock cycles.

Because of the overlap, coincident edges still produce two equal pulses, never no pulse at all. This keeps the error response linear through zero and removes the dead zone that a plain edge comparator shows for very small offsets. A saturating signed accumulator integrates the pulses. It gains one per cycle while only up is high and loses one per cycle while only down is high, so it plays the role of the integrating capacitor of a charge pump. Both inputs pass through two synchronising flops before their rising edges are detected.

Top module: `edge_phase_det`

## Requirements
- R1: While `rst` is high, `up_o` and `dn_o` are 0 at the next clock edge and `acc_o` is 0. This holds even if a pulse was in progress.
- R2: If A rises `d` cycles before B (d >= 0), `up_o` is high for `d + DELAY` consecutive cycles and `dn_o` for `DELAY` cycles.
- R3: If B rises `d` cycles before A (d > 0), `dn_o` is high for `d + DELAY` cycles and `up_o` for `DELAY` cycles.
- R4: If both inputs rise in the same cycle, `up_o` and `dn_o` rise together and each stays high for exactly `DELAY` cycles.
- R5: `up_o` and `dn_o` always fall in the same clock cycle, and a pulse never ends before the other input's pulse has begun.
- R6: Each cycle, `acc_o` (two's complement) rises by 1 when only `up_o` is high, falls by 1 when only `dn_o` is high, and is otherwise unchanged. Over one edge pair, its net change therefore equals the signed lead of A over B.
- R7: `acc_o` saturates at +(2^(ACC_W-1))-1 and at -(2^(ACC_W-1)) and does not wrap.
- R8: A further rising edge on an input whose pulse is already high has no effect on pulse widths until both pulses have cleared.
- R9: A rising edge on an input is first seen by the clock edge that samples the input high. The matching pulse output goes high after the second clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | PWM input A (asynchronous) |
| b_in | input | 1 | PWM input B (asynchronous) |
| up_o | output | 1 | Up error pulse, started by a rising edge on A |
| dn_o | output | 1 | Down error pulse, started by a rising edge on B |
| acc_o | output | ACC_W | Signed saturating net-error accumulator |

## Verification
The hardest situation to reach from the ports is a second rising edge on an input whose pulse is still waiting for the other edge. Producing it takes a one-cycle low glitch on A after its first edge and before B rises, and the glitch has to survive the synchronisers. The stimulus produces this glitch on purpose in directed pairs and, at random, in pairs where A leads by three or more cycles. Saturation at both limits is reached by chaining pairs with large offsets of one sign and then the other.

// File: rtl/epd_pkg.sv
package epd_pkg;

    // Synchroniser chain state for one asynchronous input
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_st_t;

endpackage

// File: rtl/epd_edge_sync.sv
module epd_edge_sync
    import epd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.sync & ~st_q.prev;

    // R9: a detected rise lasts exactly one cycle
    a_r9_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/epd_pulse_ctl.sv
module epd_pulse_ctl #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_a,
    input  logic rise_b,
    output logic up,
    output logic dn
);

    localparam int CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    typedef struct packed {
        logic             up;
        logic             dn;
        logic [CNT_W-1:0] cnt;
    } pc_st_t;

    pc_st_t st_d, st_q;
    logic   both;
    logic   release_now;

    always_comb begin
        st_d        = st_q;
        both        = st_q.up & st_q.dn;
        release_now = both && (st_q.cnt == LAST);
        if (release_now) begin
            st_d.up  = 1'b0;
            st_d.dn  = 1'b0;
            st_d.cnt = '0;
        end else begin
            st_d.up = st_q.up | rise_a;
            st_d.dn = st_q.dn | rise_b;
            if (both) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up = st_q.up;
    assign dn = st_q.dn;

    // R5: up ends only in the cycle that dn ends, and vice versa
    a_r5_fall_together: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.up) |-> ($fell(st_q.dn)));
    a_r5_fall_together_dn: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.dn) |-> ($fell(st_q.up)));
    // R5: overlap counter never passes its last value
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);
    // R8: a set flag holds until the joint release
    a_r8_hold_up: assert property (@(posedge clk) disable iff (rst)
        (st_q.up && !st_q.dn) |=> st_q.up);
    a_r8_hold_dn: assert property (@(posedge clk) disable iff (rst)
        (st_q.dn && !st_q.up) |=> st_q.dn);

endmodule

// File: rtl/epd_err_acc.sv
module epd_err_acc #(
    parameter int ACC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up,
    input  logic                    dn,
    output logic signed [ACC_W-1:0] acc
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

    logic signed [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (up && !dn && (acc_q != ACC_MAX)) begin
            acc_d = acc_q + ONE;
        end else if (dn && !up && (acc_q != ACC_MIN)) begin
            acc_d = acc_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;

    // R6: equal overlap leaves the integrator untouched
    a_r6_cancel: assert property (@(posedge clk) disable iff (rst)
        (up && dn) |=> $stable(acc_q));
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        (!up && !dn) |=> $stable(acc_q));
    // R7: no wrap from the top limit to the bottom or back
    a_r7_no_wrap_hi: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_MAX) |=> (acc_q != ACC_MIN));
    a_r7_no_wrap_lo: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_MIN) |=> (acc_q != ACC_MAX));

endmodule

// File: rtl/edge_phase_det.sv
module edge_phase_det #(
    parameter int DELAY = 3,
    parameter int ACC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    a_in,
    input  logic                    b_in,
    output logic                    up_o,
    output logic                    dn_o,
    output logic signed [ACC_W-1:0] acc_o
);

    logic rise_a, rise_b;
    logic up_w, dn_w;

    epd_edge_sync u_sync_a (
        .clk  (clk),
        .rst  (rst),
        .din  (a_in),
        .rise (rise_a)
    );

    epd_edge_sync u_sync_b (
        .clk  (clk),
        .rst  (rst),
        .din  (b_in),
        .rise (rise_b)
    );

    epd_pulse_ctl #(.DELAY(DELAY)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .rise_a (rise_a),
        .rise_b (rise_b),
        .up     (up_w),
        .dn     (dn_w)
    );

    epd_err_acc #(.ACC_W(ACC_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .up  (up_w),
        .dn  (dn_w),
        .acc (acc_o)
    );

    assign up_o = up_w;
    assign dn_o = dn_w;

    // R2: a pulse on up starts only after an edge on A was detected
    a_r2_up_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(up_w) |-> $past(rise_a));
    // R3: a pulse on dn starts only after an edge on B was detected
    a_r3_dn_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(dn_w) |-> $past(rise_b));

endmodule

// File: tb/sim_edge_phase_det.sv
module sim_edge_phase_det;

    localparam int DELAY = 3;
    localparam int ACC_W = 8;
    localparam int AMAX  = (1 << (ACC_W - 1)) - 1;
    localparam int AMIN  = -(1 << (ACC_W - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic up_o, dn_o;
    logic signed [ACC_W-1:0] acc_o;

    int total = 0;
    int bad   = 0;
    int exp_acc = 0;
    bit finished = 1'b0;

    edge_phase_det #(.DELAY(DELAY), .ACC_W(ACC_W)) u0 (
        .clk   (clk),
        .rst   (rst),
        .a_in  (a_in),
        .b_in  (b_in),
        .up_o  (up_o),
        .dn_o  (dn_o),
        .acc_o (acc_o)
    );

    always #10 clk = ~clk;

    function automatic int clamp(input int v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One edge pair: A rises at step ta, B at step tb; d = tb - ta
    task automatic run_pair(input int d, input bit glitch);
        int ta, tb, n;
        int upc, dnc, upf, dnf, upl, dnl;
        ta = (d >= 0) ? 3 : 3 - d;
        tb = (d >= 0) ? 3 + d : 3;
        n = imax(ta, tb) + DELAY + 8;
        upc = 0; dnc = 0; upf = -1; dnf = -1; upl = -1; dnl = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (up_o) begin upc++; upl = i; if (upf < 0) upf = i; end
            if (dn_o) begin dnc++; dnl = i; if (dnf < 0) dnf = i; end
            a_in = (i >= ta);
            if (glitch && i == ta + 1) a_in = 1'b0;
            b_in = (i >= tb);
        end
        @(negedge clk);
        a_in = 1'b0;
        b_in = 1'b0;
        repeat (4) @(negedge clk);
        exp_acc = clamp(exp_acc + d);
        if (d > 0) begin
            check(upc == d + DELAY, "R2 up width", upc, d + DELAY);
            check(dnc == DELAY, "R2 dn width", dnc, DELAY);
        end else if (d < 0) begin
            check(dnc == DELAY - d, "R3 dn width", dnc, DELAY - d);
            check(upc == DELAY, "R3 up width", upc, DELAY);
        end else begin
            check(upc == DELAY && dnc == DELAY, "R4 equal widths", upc * 100 + dnc, DELAY * 101);
            check(upf == dnf, "R4 joint rise", upf, dnf);
        end
        if (glitch) check(upc == d + DELAY, "R8 re-edge ignored", upc, d + DELAY);
        check(upl == dnl, "R5 joint fall", upl, dnl);
        check(upf == ta + 3, "R9 up latency", upf, ta + 3);
        check(dnf == tb + 3, "R9 dn latency", dnf, tb + 3);
        check(int'(acc_o) == exp_acc, "R6 net error", int'(acc_o), exp_acc);
    endtask

    initial begin
        int d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!up_o && !dn_o, "R1 reset pulses", {up_o, dn_o}, 0);
        check(acc_o == 0, "R1 reset acc", int'(acc_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_pair(0, 1'b0);
        run_pair(1, 1'b0);
        run_pair(-1, 1'b0);
        run_pair(5, 1'b0);
        run_pair(-7, 1'b0);
        run_pair(6, 1'b1);

        for (int k = 0; k < 24; k++) begin
            d = int'($urandom_range(24)) - 12;
            run_pair(d, (d >= 3) && ($urandom_range(1) == 1));
        end

        // R7: drive to the upper limit, then to the lower one
        for (int k = 0; k < 10; k++) run_pair(20, 1'b0);
        check(int'(acc_o) == AMAX, "R7 top limit", int'(acc_o), AMAX);
        run_pair(4, 1'b0);
        check(int'(acc_o) == AMAX, "R7 held at top", int'(acc_o), AMAX);
        for (int k = 0; k < 15; k++) run_pair(-20, 1'b0);
        check(int'(acc_o) == AMIN, "R7 bottom limit", int'(acc_o), AMIN);
        run_pair(-3, 1'b0);
        check(int'(acc_o) == AMIN, "R7 held at bottom", int'(acc_o), AMIN);

        // R1: reset in the middle of a pulse
        @(negedge clk);
        a_in = 1'b1;
        repeat (5) @(negedge clk);
        check(up_o == 1'b1, "R1 pulse before reset", up_o, 1);
        rst = 1'b1;
        a_in = 1'b0;
        @(negedge clk);
        check(!up_o && !dn_o, "R1 mid-pulse reset", {up_o, dn_o}, 0);
        check(acc_o == 0, "R1 acc cleared", int'(acc_o), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_acc = 0;
        repeat (2) @(negedge clk);
        run_pair(2, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule